// File: doc/BRIEF.md
# Off-Board Access Sequencer

Each processor board carries one instance of this sequencer. It takes the local processor's memory accesses and sorts each one into one of two kinds. The first kind targets on-board memory, and the sequencer finishes it locally. The second kind targets a window of addresses that belongs to the shared inter-processor bus.

For a shared-bus access, the sequencer raises a bus request and waits for the grant that arrives down a daisy chain. It then takes ownership of the bus and drops its request. After that it drives the address strobe until the remote side answers. The remote side answers with a data acknowledge or with a bus error. If the remote side says nothing within a set number of cycles, the access also ends in an error. The outcome goes back to the processor as a one-cycle completion pulse or a one-cycle error pulse.

While the slot is neither requesting nor owning the bus, a grant on grant-in passes on to grant-out, so the slots further down the chain still get the bus. The request, grant, acknowledge and error inputs come from outside the local clock domain, and each one passes through two flip-flops before the state machine looks at it. The address is assumed stable, and synchronous to the local clock, while the request is held.

Top module: `offboard_seq`

## Requirements
- R1: An access is off-board exactly when WIN_BASE <= addr_i < WIN_BASE + WIN_SIZE (defaults 0x8000 and 0x4000). Every other address is on-board.
- R2: An on-board access produces a single-cycle done_o pulse on the third rising edge after req_i rises, and bus_req_o stays low throughout.
- R3: An off-board access raises bus_req_o on the third rising edge after req_i rises. bus_req_o stays high, with busy_o low, until a grant is received.
- R4: When bg_in_i is seen while the slot is requesting, busy_o rises and bus_req_o falls on the same edge. Throughout the time busy_o is high, bg_out_o stays low.
- R5: as_o rises one cycle after busy_o. It stays high until the transfer ends, and it is never high without busy_o.
- R6: An acknowledge during the address phase ends the transfer with a one-cycle done_o pulse, and busy_o and as_o fall on the same edge, three rising edges after ack_i rises.
- R7: A bus error during the address phase ends the transfer with a one-cycle err_o pulse. If ack_i and berr_i arrive together, the result is err_o only.
- R8: If neither answer arrives, as_o stays high for exactly TIMEOUT cycles (default 16), and then err_o pulses.
- R9: While the slot is neither requesting nor busy, bg_out_o follows bg_in_i two cycles later.
- R10: ack_i and berr_i have no effect when no address phase is in progress: done_o and err_o stay low.
- R11: Each request produces exactly one completion. Holding req_i high after the completion starts no new access until req_i has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Local access request, held until done_o or err_o |
| addr_i | input | AW | Local access address |
| bg_in_i | input | 1 | Daisy-chain grant from the upstream slot |
| ack_i | input | 1 | Data acknowledge from the remote side |
| berr_i | input | 1 | Bus error from the remote side |
| bus_req_o | output | 1 | Shared-bus request |
| busy_o | output | 1 | Bus ownership held by this slot |
| as_o | output | 1 | Address strobe on the shared bus |
| bg_out_o | output | 1 | Grant passed to the downstream slot |
| done_o | output | 1 | One-cycle successful completion pulse |
| err_o | output | 1 | One-cycle bus error pulse |

## Verification
A state machine stuck in the request state shows as bus_req_o staying high after a grant has arrived, and this is visible three cycles after the grant. A state machine that skips the ownership state shows as as_o rising on the same edge as busy_o, or as bg_out_o going high while busy_o is high. A wrong timer reset or a wrong timer limit changes the measured width of the address strobe on a timed-out transfer by at least one cycle. A lost completion leaves the requester without a done_o or err_o pulse within the three cycles allowed after the answer arrives. A duplicated completion shows as a second pulse while req_i is still held.

// File: rtl/offboard_pkg.sv
package offboard_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_OWN,
    ST_ADDR,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/addr_window.sv
module addr_window #(
  parameter int          AW       = 16,
  parameter logic [AW-1:0] WIN_BASE = 16'h8000,
  parameter logic [AW:0]   WIN_SIZE = 17'h04000
) (
  input  logic [AW-1:0] addr_i,
  output logic          off_o
);
  localparam logic [AW:0] WIN_END = {1'b0, WIN_BASE} + WIN_SIZE;

  assign off_o = ({1'b0, addr_i} >= {1'b0, WIN_BASE}) && ({1'b0, addr_i} < WIN_END);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import offboard_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic off_i,
  input  logic bg_s_i,
  input  logic ack_s_i,
  input  logic berr_s_i,
  output logic bus_req_o,
  output logic busy_o,
  output logic as_o,
  output logic pass_o,
  output logic done_o,
  output logic err_o
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);

  seq_state_e state_q, state_d;
  logic [TW-1:0] cnt_q;
  logic done_d, err_d;
  logic expired;

  assign expired = (cnt_q == T_LAST);

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_s_i) begin
        if (off_i) state_d = ST_REQ;
        else begin
          done_d  = 1'b1;
          state_d = ST_HOLD;
        end
      end
      ST_REQ:  if (bg_s_i) state_d = ST_OWN;
      ST_OWN:  state_d = ST_ADDR;
      ST_ADDR: begin
        if (berr_s_i || (!ack_s_i && expired)) begin
          err_d   = 1'b1;
          state_d = ST_HOLD;
        end else if (ack_s_i) begin
          done_d  = 1'b1;
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: if (!req_s_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      err_o   <= err_d;
      if (state_q == ST_ADDR) cnt_q <= cnt_q + 1'b1;
      else                    cnt_q <= '0;
    end
  end

  assign bus_req_o = (state_q == ST_REQ);
  assign busy_o    = (state_q == ST_OWN) || (state_q == ST_ADDR);
  assign as_o      = (state_q == ST_ADDR);
  assign pass_o    = (state_q == ST_IDLE) || (state_q == ST_HOLD);

  // R4: ownership taken only out of a pending request, and the request is dropped
  a_r4_own_from_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(bus_req_o) && !bus_req_o);
  a_r4_req_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_req_o, busy_o}));
  // R5: strobe follows ownership by one cycle
  a_r5_as_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(as_o) |-> $past(busy_o) && !$past(as_o));
  // R7: only one outcome per completion
  a_r7_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  // R8: expired timer with no answer yields an error
  a_r8_timeout_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_o && expired && !ack_s_i && !berr_s_i) |=> err_o && !as_o);
  // R10: outcomes only after an address phase or a local decision
  a_r10_err_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(as_o));
endmodule

// File: rtl/offboard_seq.sv
module offboard_seq #(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] WIN_BASE = 16'h8000,
  parameter logic [AW:0]   WIN_SIZE = 17'h04000,
  parameter int            TIMEOUT  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          bg_in_i,
  input  logic          ack_i,
  input  logic          berr_i,
  output logic          bus_req_o,
  output logic          busy_o,
  output logic          as_o,
  output logic          bg_out_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic req_s, bg_s, ack_s, berr_s;
  logic off, pass;

  assign raw_in = {berr_i, ack_i, bg_in_i, req_i};
  assign {berr_s, ack_s, bg_s, req_s} = syn_in;

  sync2 #(.W(NSYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  addr_window #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_win (
    .addr_i(addr_i),
    .off_o (off)
  );

  seq_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_s_i  (req_s),
    .off_i    (off),
    .bg_s_i   (bg_s),
    .ack_s_i  (ack_s),
    .berr_s_i (berr_s),
    .bus_req_o(bus_req_o),
    .busy_o   (busy_o),
    .as_o     (as_o),
    .pass_o   (pass),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  assign bg_out_o = bg_s && pass;

  // R4: chain broken downstream while this slot owns the bus
  a_r4_no_pass_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !bg_out_o);
  // R5: strobe never without ownership
  a_r5_as_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_o |-> busy_o);
  // R2: bus untouched on completion pulses
  a_r2_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o && !as_o);
endmodule

// File: tb/offboard_seq_tb.sv
module offboard_seq_tb;
  localparam int AW = 16;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, bg_in = 1'b0, ack = 1'b0, berr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic bus_req, busy, as_s, bg_out, done, err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  offboard_seq #(.AW(AW), .TIMEOUT(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .bg_in_i(bg_in), .ack_i(ack), .berr_i(berr),
    .bus_req_o(bus_req), .busy_o(busy), .as_o(as_s), .bg_out_o(bg_out),
    .done_o(done), .err_o(err)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic t_reset;
    check(!bus_req && !busy && !as_s && !bg_out && !done && !err, "R2 reset outputs low",
          {bus_req, busy, as_s, bg_out, done, err}, 0);
  endtask

  // R1/R2: on-board access
  task automatic t_local(input logic [AW-1:0] a);
    addr = a; req = 1'b1;
    edges(2);
    check(!done, "R2 local no early done", done, 0);
    edges(1);
    check(done && !bus_req, "R1 R2 local done at edge 3", {done, bus_req}, 2);
    edges(1);
    check(!done && !bus_req, "R2 local done one cycle", {done, bus_req}, 0);
    req = 1'b0;
    edges(4);
  endtask

  // R3..R8: off-board access; mode 0=ack 1=berr 2=both 3=none
  task automatic t_remote(input logic [AW-1:0] a, input int mode);
    int n;
    addr = a; req = 1'b1;
    edges(3);
    check(bus_req && !busy, "R1 R3 request raised", {bus_req, busy}, 2);
    edges(5);
    check(bus_req && !busy, "R3 request held without grant", {bus_req, busy}, 2);
    bg_in = 1'b1;
    edges(3);
    check(busy && !bus_req && !as_s && !bg_out, "R4 ownership taken",
          {busy, bus_req, as_s, bg_out}, 8);
    edges(1);
    check(as_s && busy, "R5 strobe after busy", {as_s, busy}, 3);
    if (mode == 3) begin
      n = 0;
      while (as_s && n < 100) begin
        if (bg_out) check(1'b0, "R4 grant blocked while busy", bg_out, 0);
        n++;
        @(negedge clk);
      end
      bg_in = 1'b0;
      check(n == TO, "R8 strobe width", n, TO);
      check(err && !done && !busy, "R8 timeout error", {err, done, busy}, 4);
    end else begin
      bg_in = 1'b0;
      ack = (mode == 0 || mode == 2);
      berr = (mode == 1 || mode == 2);
      edges(2);
      check(as_s && !done && !err, "R6 strobe held until answer", {as_s, done, err}, 4);
      edges(1);
      if (mode == 0)
        check(done && !err && !busy && !as_s, "R6 ack completes", {done, err, busy, as_s}, 8);
      else
        check(err && !done && !busy && !as_s, "R7 error completes", {done, err, busy, as_s}, 4);
      ack = 1'b0; berr = 1'b0;
    end
    edges(1);
    check(!done && !err, "R6 R7 one-cycle outcome", {done, err}, 0);
    req = 1'b0;
    edges(4);
  endtask

  // R9: pass-through when idle
  task automatic t_pass;
    bg_in = 1'b1;
    edges(1);
    check(!bg_out, "R9 grant not yet through", bg_out, 0);
    edges(1);
    check(bg_out, "R9 grant passed", bg_out, 1);
    bg_in = 1'b0;
    edges(2);
    check(!bg_out, "R9 grant release passed", bg_out, 0);
  endtask

  // R10: stray answers ignored
  task automatic t_stray;
    int hits = 0;
    ack = 1'b1; berr = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done || err) hits++;
    end
    ack = 1'b0; berr = 1'b0;
    edges(4);
    check(hits == 0, "R10 stray ack/berr ignored", hits, 0);
  endtask

  // R11: single completion while req held
  task automatic t_hold;
    int pulses = 0;
    addr = 16'h0100; req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    check(pulses == 1 && !bus_req, "R11 one completion per request", pulses, 1);
    req = 1'b0;
    edges(4);
  endtask

  initial begin
    edges(3);
    t_reset();
    rst_n = 1'b1;
    edges(2);
    t_reset();
    t_local(16'h7FFF);
    t_local(16'hC000);
    t_local(16'h0000);
    t_remote(16'h8000, 0);
    t_remote(16'hBFFF, 1);
    t_remote(16'h9234, 2);
    t_remote(16'hA000, 3);
    t_pass();
    t_stray();
    t_remote(16'h8001, 0);
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule